// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a small 32-bit processor that fetches, decodes and completes one instruction per clock edge. It has a program counter, thirty-two general registers, an arithmetic unit, a sign extender, next-address logic for branches and jumps, and a combinational decoder that drives the multiplexers between them. Instruction words and data words sit in two word-addressed arrays inside the block.

A test harness fills both arrays through a preload port while reset is held. It then releases reset and lets the program run. Afterwards it reads any register through a debug port. The current PC is also an output. The instruction set covers word load and store, five register-register operations, branch-on-equal and an absolute jump. Any other opcode only advances the PC.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a clock edge, the PC becomes 0 and every register becomes 0. Reset is synchronous and active high.
- R2: Any instruction that is neither a taken branch nor a jump leaves the PC at PC+4 after the edge.
- R3: Register-register instructions (opcode 0) write rd (bits 15:11) with the result of rs (bits 25:21) and rt (bits 20:16). The funct field (bits 5:0) selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than. Any other funct writes nothing.
- R4: Opcode 0x23 loads rt from data word (rs + sign-extended imm[15:0]) >> 2. Opcode 0x2B stores rt to that word on the edge. A load sees a store from an earlier cycle.
- R5: Opcode 0x04 compares rs and rt. If they are equal, the PC becomes PC+4 + (sign-extended imm << 2). Otherwise it becomes PC+4. Backward offsets work.
- R6: Opcode 0x02 sets the PC to {PC+4[31:28], instr[25:0], 2'b00}.
- R7: Register 0 always reads as zero, and writes aimed at it are discarded.
- R8: An opcode outside the set above writes no register and no data word, and only advances the PC by 4.
- R9: The preload port writes instruction or data word `pre_addr` on a clock edge. `dbg_data` combinationally shows register `dbg_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_imem_we | input | 1 | Preload write strobe for instruction memory |
| pre_dmem_we | input | 1 | Preload write strobe for data memory |
| pre_addr | input | LAW | Word index for the preload write |
| pre_wdata | input | 32 | Preload write data |
| dbg_sel | input | 5 | Register number for the debug read |
| dbg_data | output | 32 | Contents of the selected register |
| pc | output | 32 | Current program counter |

## Verification
The hardest case to reach from the ports is the set of skipped instructions. These are words that a taken forward branch or a jump steps over. They are placed so that executing them would leave a visible mark in a register. The bench lays a program into instruction memory in which the words at the skipped slots would write registers that must stay zero. It also samples the PC on the exact edges that follow each branch and jump. The same program also covers a backward self-branch, a negative load offset, a store followed by a load of the same word, a write aimed at register 0, an unknown funct and an unknown opcode.

// File: rtl/sc_core.sv
module sc_core #(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pre_imem_we,
  input  logic           pre_dmem_we,
  input  logic [LAW-1:0] pre_addr,
  input  logic [31:0]    pre_wdata,
  input  logic [4:0]     dbg_sel,
  output logic [31:0]    dbg_data,
  output logic [31:0]    pc
);
  localparam logic [5:0] OP_RR = 6'h00, OP_LW = 6'h23, OP_SW = 6'h2B,
                         OP_BEQ = 6'h04, OP_J = 6'h02;
  localparam logic [3:0] AC_AND = 4'b0000, AC_OR = 4'b0001, AC_ADD = 4'b0010,
                         AC_SUB = 4'b0110, AC_SLT = 4'b0111;

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] rf [32];
  logic [31:0] pc_q, instr, pc_inc, br_tgt, j_tgt, imm_x;
  logic [31:0] rs_val, rt_val, alu_b, alu_res, mem_rd, wb_data;
  logic [4:0]  rs, rt, rd, wr_reg;
  logic [5:0]  op, funct;
  logic [3:0]  alu_ctl;
  logic [1:0]  alu_op;
  logic        reg_dst, alu_src, mem_to_reg, reg_write, mem_read, mem_write, branch, jump;
  logic        funct_ok, zero, reg_we;

  assign pc     = pc_q;
  assign instr  = imem[pc_q[IAW+1:2]];
  assign op     = instr[31:26];
  assign rs     = instr[25:21];
  assign rt     = instr[20:16];
  assign rd     = instr[15:11];
  assign funct  = instr[5:0];
  assign imm_x  = {{16{instr[15]}}, instr[15:0]};
  assign pc_inc = pc_q + 32'd4;
  assign br_tgt = pc_inc + {imm_x[29:0], 2'b00};
  assign j_tgt  = {pc_inc[31:28], instr[25:0], 2'b00};

  always_comb begin
    reg_dst = 1'b0; alu_src = 1'b0; mem_to_reg = 1'b0; reg_write = 1'b0;
    mem_read = 1'b0; mem_write = 1'b0; branch = 1'b0; jump = 1'b0; alu_op = 2'b00;
    case (op)
      OP_RR:  begin reg_dst = 1'b1; reg_write = 1'b1; alu_op = 2'b10; end
      OP_LW:  begin alu_src = 1'b1; mem_to_reg = 1'b1; reg_write = 1'b1; mem_read = 1'b1; end
      OP_SW:  begin alu_src = 1'b1; mem_write = 1'b1; end
      OP_BEQ: begin branch = 1'b1; alu_op = 2'b01; end
      OP_J:   jump = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    funct_ok = 1'b1;
    case (alu_op)
      2'b00: alu_ctl = AC_ADD;
      2'b01: alu_ctl = AC_SUB;
      default: begin
        case (funct)
          6'h20: alu_ctl = AC_ADD;
          6'h22: alu_ctl = AC_SUB;
          6'h24: alu_ctl = AC_AND;
          6'h25: alu_ctl = AC_OR;
          6'h2A: alu_ctl = AC_SLT;
          default: begin alu_ctl = AC_AND; funct_ok = 1'b0; end
        endcase
      end
    endcase
  end

  assign rs_val = (rs == 5'd0) ? 32'd0 : rf[rs];
  assign rt_val = (rt == 5'd0) ? 32'd0 : rf[rt];
  assign alu_b  = alu_src ? imm_x : rt_val;

  always_comb begin
    case (alu_ctl)
      AC_AND:  alu_res = rs_val & alu_b;
      AC_OR:   alu_res = rs_val | alu_b;
      AC_ADD:  alu_res = rs_val + alu_b;
      AC_SUB:  alu_res = rs_val - alu_b;
      AC_SLT:  alu_res = {31'd0, $signed(rs_val) < $signed(alu_b)};
      default: alu_res = 32'd0;
    endcase
  end

  assign zero    = (alu_res == 32'd0);
  assign mem_rd  = mem_read ? dmem[alu_res[DAW+1:2]] : 32'd0;
  assign wb_data = mem_to_reg ? mem_rd : alu_res;
  assign wr_reg  = reg_dst ? rd : rt;
  assign reg_we  = reg_write && funct_ok && (wr_reg != 5'd0);
  assign dbg_data = (dbg_sel == 5'd0) ? 32'd0 : rf[dbg_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= 32'd0;
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    end else begin
      if (jump)                 pc_q <= j_tgt;
      else if (branch && zero)  pc_q <= br_tgt;
      else                      pc_q <= pc_inc;
      if (reg_we) rf[wr_reg] <= wb_data;
    end
  end

  always_ff @(posedge clk) begin
    if (pre_imem_we) imem[pre_addr[IAW-1:0]] <= pre_wdata;
  end

  always_ff @(posedge clk) begin
    if (pre_dmem_we)                dmem[pre_addr[DAW-1:0]] <= pre_wdata;
    else if (!rst && mem_write)     dmem[alu_res[DAW+1:2]] <= rt_val;
  end
endmodule

module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic [31:0] rs_val
);
  a_r1_reset_pc: assert property (@(posedge clk) rst |=> pc == 32'd0);
  a_r2_aligned: assert property (@(posedge clk) disable iff (rst) pc[1:0] == 2'b00);
  a_r2_seq_pc: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] != 6'h04 && instr[31:26] != 6'h02) |=> pc == $past(pc) + 32'd4);
  a_r6_jump: assert property (@(posedge clk) disable iff (rst)
    instr[31:26] == 6'h02 |=> pc == {$past(pc[31:28] + 4'd0), $past(instr[25:0]), 2'b00}
                                 || pc[27:0] == {$past(instr[25:0]), 2'b00});
  a_r5_beq_pc: assert property (@(posedge clk) disable iff (rst)
    instr[31:26] == 6'h04 |=> (pc == $past(pc) + 32'd4) ||
      (pc == $past(pc) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00}));
  a_r7_zero_reg: assert property (@(posedge clk) disable iff (rst)
    instr[25:21] == 5'd0 |-> rs_val == 32'd0);
endmodule

bind sc_core sc_core_chk u_chk (
  .clk(clk), .rst(rst), .pc(pc_q), .instr(instr), .rs_val(rs_val)
);

// File: tb/sim_sc_core.sv
`timescale 1ns/1ps
module sim_sc_core;
  localparam int LAW = 6;
  logic clk = 1'b0, rst = 1'b1, pre_imem_we = 1'b0, pre_dmem_we = 1'b0;
  logic [LAW-1:0] pre_addr = '0;
  logic [31:0] pre_wdata = '0;
  logic [4:0] dbg_sel = '0;
  logic [31:0] dbg_data, pc;
  int n_run = 0, n_fail = 0, edges = 0;

  sc_core u0 (.*);

  always #2 clk = ~clk;
  always @(posedge clk) edges <= edges + 1;

  function automatic logic [31:0] rr(input int s, input int t, input int d, input int f);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, 6'(f)};
  endfunction
  function automatic logic [31:0] it(input int o, input int s, input int t, input logic [15:0] im);
    return {6'(o), 5'(s), 5'(t), im};
  endfunction

  localparam int NP = 23;
  localparam logic [31:0] PROG [NP] = '{
    it(6'h23, 0, 1, 16'd0),        // 0 lw r1
    it(6'h23, 0, 2, 16'd4),        // 1 lw r2
    rr(1, 2, 3, 6'h20),            // 2 add
    rr(1, 2, 4, 6'h22),            // 3 sub
    rr(1, 2, 5, 6'h24),            // 4 and
    rr(1, 2, 6, 6'h25),            // 5 or
    rr(2, 1, 7, 6'h2A),            // 6 slt true
    rr(1, 2, 8, 6'h2A),            // 7 slt false
    it(6'h2B, 0, 4, 16'd8),        // 8 sw r4
    it(6'h23, 0, 9, 16'd8),        // 9 lw r9
    rr(1, 1, 0, 6'h20),            // 10 write r0
    it(6'h04, 1, 2, 16'd5),        // 11 beq not taken
    it(6'h04, 3, 3, 16'd2),        // 12 beq taken -> 15
    rr(1, 1, 10, 6'h20),           // 13 skipped
    rr(1, 1, 10, 6'h20),           // 14 skipped
    32'hFC2A_5001,                 // 15 unknown opcode
    {6'h02, 26'd19},               // 16 jump -> 19
    rr(1, 1, 11, 6'h20),           // 17 skipped
    rr(1, 1, 11, 6'h20),           // 18 skipped
    rr(1, 1, 14, 6'h3F),           // 19 unknown funct
    it(6'h23, 3, 12, 16'hFFFC),    // 20 lw r12, -4(r3)
    rr(12, 4, 13, 6'h20),          // 21 add
    it(6'h04, 0, 0, 16'hFFFF)      // 22 self loop
  };

  localparam int NE = 15;
  localparam logic [36:0] EXPV [NE] = '{
    {5'd0,  32'd0},          // R7
    {5'd1,  32'd7},          // R4
    {5'd2,  32'hFFFF_FFFD},  // R4
    {5'd3,  32'd4},          // R3
    {5'd4,  32'd10},         // R3
    {5'd5,  32'd5},          // R3
    {5'd6,  32'hFFFF_FFFF},  // R3
    {5'd7,  32'd1},          // R3
    {5'd8,  32'd0},          // R3
    {5'd9,  32'd10},         // R4
    {5'd10, 32'd0},          // R5 R8
    {5'd11, 32'd0},          // R6
    {5'd12, 32'd7},          // R4
    {5'd13, 32'd17},         // R4
    {5'd14, 32'd0}           // R3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic pc_at(input int k, input logic [31:0] exp, input string req);
    while (edges < k) @(negedge clk);
    chk(req, pc, exp);
  endtask

  initial begin : watchdog
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < NP; i++) begin
      pre_imem_we = 1'b1; pre_addr = LAW'(i); pre_wdata = PROG[i];
      @(negedge clk);
    end
    pre_imem_we = 1'b0; pre_dmem_we = 1'b1;
    pre_addr = 0; pre_wdata = 32'd7;          @(negedge clk);
    pre_addr = 1; pre_wdata = 32'hFFFF_FFFD;  @(negedge clk);
    pre_dmem_we = 1'b0;
    chk("R1 reset pc", pc, 32'd0);
    dbg_sel = 5'd1; #0.1;
    chk("R1 reset reg", dbg_data, 32'd0);
    chk("R9 idle debug", dbg_data, 32'd0);
    rst = 1'b0;
    edges = 0;
    pc_at(1,  32'd4,  "R2 sequential");
    pc_at(12, 32'd48, "R5 not taken");
    pc_at(13, 32'd60, "R5 taken forward");
    pc_at(14, 32'd64, "R8 unknown opcode advances");
    pc_at(15, 32'd76, "R6 jump target");
    pc_at(16, 32'd80, "R2 after unknown funct");
    pc_at(19, 32'd88, "R5 reach loop");
    pc_at(25, 32'd88, "R5 backward self loop");
    for (int i = 0; i < NE; i++) begin
      dbg_sel = EXPV[i][36:32];
      #0.1;
      chk($sformatf("R9 reg%0d (R3/R4/R7 result)", EXPV[i][36:32]), dbg_data, EXPV[i][31:0]);
    end
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 rerun pc", pc, 32'd0);
    dbg_sel = 5'd13; #0.1;
    chk("R1 rerun reg cleared", dbg_data, 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule